// File: doc/BRIEF.md
# Shadow Page Remapping TLB

This block sits inside a memory controller. It turns addresses in a reserved "shadow" physical range into real DRAM addresses at 4 KB page grain. Software builds a dense table in memory with one 32-bit word per shadow page. Each word names the real page frame that backs that shadow page, and software writes the table's base address into a configuration register. Neighbouring shadow pages may point at unrelated frames. The CPU can therefore treat one contiguous shadow superpage as a single mapping while the data stays spread over scattered base pages. Any shadow page can also be steered to a frame of a chosen cache colour, and no data is copied in either case.

A small fully associative buffer holds recent shadow-to-frame pairs. A request that hits, or that lies outside the shadow range, is answered in the cycle after it is accepted. A miss stops new requests, issues one table read, installs the returned frame in the slot chosen by a rotating pointer, and answers in the cycle after the read data arrives. A flush pulse clears every slot. Writing the table base register also clears every slot.

Top module: `shadow_remap_tlb`

## Requirements
- R1: The low 12 bits of each response address equal the low 12 bits of the request that produced it.
- R2: A request whose page number is below SHADOW_BASE_PAGE, or at or above SHADOW_BASE_PAGE+SHADOW_PAGES, is answered one cycle after acceptance with the address unchanged, and no table read is made.
- R3: A shadow request that misses makes exactly one table read at address table_base + 4*(page - SHADOW_BASE_PAGE). The response arrives in the cycle after mem_rvalid_i is seen. Its bits [31:12] equal mem_rdata_i.
- R4: A shadow request whose page is held in the buffer is answered one cycle after acceptance, with no table read.
- R5: After reset req_ready_o is 1 and rsp_valid_o and mem_req_o are 0. From the acceptance of a miss until its response, req_ready_o is 0, while mem_req_o stays 1 with a stable mem_addr_o until mem_rvalid_i.
- R6: The buffer has 8 slots that are filled in rotating order. The ninth distinct page evicts the first one filled, and the pages filled second through eighth remain hits.
- R7: A flush_i pulse invalidates every slot, so the next access to any previously held page makes a table read.
- R8: A cfg_we_i write loads the table base from cfg_base_i and invalidates every slot. Later misses read from the new table.
- R9: Consecutive shadow pages translate independently, each to the frame stored in its own table word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Invalidate all buffer slots |
| cfg_we_i | input | 1 | Write the table base register |
| cfg_base_i | input | 32 | New table base address |
| req_valid_i | input | 1 | Translation request valid |
| req_addr_i | input | 32 | Address to translate |
| req_ready_o | output | 1 | Request can be accepted |
| rsp_valid_o | output | 1 | One-cycle pulse, translated address valid |
| rsp_addr_o | output | 32 | Translated physical address |
| mem_req_o | output | 1 | Table read pending |
| mem_addr_o | output | 32 | Address of table word to read |
| mem_rvalid_i | input | 1 | Table read data valid |
| mem_rdata_i | input | 20 | Frame number field of the table word |

## Verification
The main function is driven with addresses just below, inside, at the last page of, and just past the shadow range. These separate the bypass path from translation and expose off-by-one errors in the range compare. Shadow pages are mapped to scattered frames in two different tables, so the bench can show that each page uses its own table word and that the base register steers the reads. Repeated pages, a ninth distinct page, a flush, and a base write together show the difference between hits and misses, rotating replacement, and invalidation, measured by response latency and the count of table reads.

// File: rtl/srtlb_pkg.sv
package srtlb_pkg;
  typedef enum logic {
    ST_IDLE,
    ST_FETCH
  } walk_state_e;
endpackage

// File: rtl/srt_region.sv
module srt_region #(
  parameter int unsigned ADDR_W           = 32,
  parameter int unsigned PAGE_BITS        = 12,
  parameter int unsigned SHADOW_BASE_PAGE = 32'h80240,
  parameter int unsigned SHADOW_PAGES     = 1024,
  localparam int unsigned VPN_W           = ADDR_W - PAGE_BITS,
  localparam int unsigned IDX_W           = (SHADOW_PAGES > 1) ? $clog2(SHADOW_PAGES) : 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              in_region_o,
  output logic [VPN_W-1:0]  vpn_o,
  output logic [IDX_W-1:0]  idx_o
);
  localparam logic [VPN_W-1:0] BASE_VPN = VPN_W'(SHADOW_BASE_PAGE);
  localparam logic [VPN_W-1:0] RANGE    = VPN_W'(SHADOW_PAGES);

  logic [VPN_W-1:0] diff;

  assign vpn_o       = addr_i[ADDR_W-1:PAGE_BITS];
  assign diff        = vpn_o - BASE_VPN;
  assign in_region_o = (vpn_o >= BASE_VPN) && (diff < RANGE);
  assign idx_o       = diff[IDX_W-1:0];
endmodule

// File: rtl/srt_cam.sv
module srt_cam #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned TAG_W   = 20,
  parameter int unsigned PFN_W   = 20,
  localparam int unsigned PTR_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               flush_i,
  input  logic [TAG_W-1:0]   lk_tag_i,
  output logic               hit_o,
  output logic [PFN_W-1:0]   hit_pfn_o,
  output logic [ENTRIES-1:0] hit_vec_o,
  input  logic               fill_i,
  input  logic [TAG_W-1:0]   fill_tag_i,
  input  logic [PFN_W-1:0]   fill_pfn_i
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [PFN_W-1:0]   pfn_q [ENTRIES];
  logic [PTR_W-1:0]   ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      ptr_q   <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        tag_q[i] <= '0;
        pfn_q[i] <= '0;
      end
    end else begin
      if (fill_i) begin
        tag_q[ptr_q] <= fill_tag_i;
        pfn_q[ptr_q] <= fill_pfn_i;
        ptr_q        <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
      end
      // flush beats a same-cycle fill
      if (flush_i)     valid_q        <= '0;
      else if (fill_i) valid_q[ptr_q] <= 1'b1;
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec_o[g] = valid_q[g] && (tag_q[g] == lk_tag_i);
  end

  always_comb begin
    hit_pfn_o = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec_o[i]) hit_pfn_o = hit_pfn_o | pfn_q[i];
    end
  end

  assign hit_o = |hit_vec_o;
endmodule

// File: rtl/srt_walker.sv
module srt_walker
  import srtlb_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned PAGE_BITS = 12,
  parameter int unsigned IDX_W     = 10,
  localparam int unsigned VPN_W    = ADDR_W - PAGE_BITS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              in_region_i,
  input  logic [VPN_W-1:0]  vpn_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              hit_i,
  input  logic [VPN_W-1:0]  hit_pfn_i,
  input  logic [ADDR_W-1:0] table_base_i,
  input  logic              mem_rvalid_i,
  input  logic [VPN_W-1:0]  mem_rdata_i,
  output logic              req_ready_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              fill_o,
  output logic [VPN_W-1:0]  fill_tag_o,
  output logic [VPN_W-1:0]  fill_pfn_o,
  output logic              rsp_valid_o,
  output logic [ADDR_W-1:0] rsp_addr_o
);
  walk_state_e          state_q;
  logic [VPN_W-1:0]     pend_vpn_q;
  logic [PAGE_BITS-1:0] pend_off_q;
  logic [ADDR_W-1:0]    mem_addr_q;
  logic                 rsp_valid_q;
  logic [ADDR_W-1:0]    rsp_addr_q;
  logic                 fire;
  logic [ADDR_W-1:0]    entry_ofs;

  assign req_ready_o = (state_q == ST_IDLE);
  assign mem_req_o   = (state_q == ST_FETCH);
  assign mem_addr_o  = mem_addr_q;
  assign fire        = req_valid_i && req_ready_o;
  assign entry_ofs   = {{(ADDR_W-IDX_W-2){1'b0}}, idx_i, 2'b00};
  assign fill_o      = mem_req_o && mem_rvalid_i;
  assign fill_tag_o  = pend_vpn_q;
  assign fill_pfn_o  = mem_rdata_i;
  assign rsp_valid_o = rsp_valid_q;
  assign rsp_addr_o  = rsp_addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      pend_vpn_q  <= '0;
      pend_off_q  <= '0;
      mem_addr_q  <= '0;
      rsp_valid_q <= 1'b0;
      rsp_addr_q  <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (fire) begin
            if (!in_region_i) begin
              rsp_valid_q <= 1'b1;
              rsp_addr_q  <= req_addr_i;
            end else if (hit_i) begin
              rsp_valid_q <= 1'b1;
              rsp_addr_q  <= {hit_pfn_i, req_addr_i[PAGE_BITS-1:0]};
            end else begin
              state_q    <= ST_FETCH;
              pend_vpn_q <= vpn_i;
              pend_off_q <= req_addr_i[PAGE_BITS-1:0];
              mem_addr_q <= table_base_i + entry_ofs;
            end
          end
        end
        ST_FETCH: begin
          if (mem_rvalid_i) begin
            state_q     <= ST_IDLE;
            rsp_valid_q <= 1'b1;
            rsp_addr_q  <= {mem_rdata_i, pend_off_q};
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/shadow_remap_tlb.sv
module shadow_remap_tlb #(
  parameter int unsigned ADDR_W           = 32,
  parameter int unsigned PAGE_BITS        = 12,
  parameter int unsigned ENTRIES          = 8,
  parameter int unsigned SHADOW_BASE_PAGE = 32'h80240,
  parameter int unsigned SHADOW_PAGES     = 1024,
  localparam int unsigned VPN_W           = ADDR_W - PAGE_BITS,
  localparam int unsigned IDX_W           = (SHADOW_PAGES > 1) ? $clog2(SHADOW_PAGES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_base_i,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              req_ready_o,
  output logic              rsp_valid_o,
  output logic [ADDR_W-1:0] rsp_addr_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [VPN_W-1:0]  mem_rdata_i
);
  logic [ADDR_W-1:0]  table_base_q;
  logic               in_region;
  logic [VPN_W-1:0]   vpn;
  logic [IDX_W-1:0]   idx;
  logic               hit;
  logic [VPN_W-1:0]   hit_pfn;
  logic [ENTRIES-1:0] hit_vec;
  logic               fill;
  logic [VPN_W-1:0]   fill_tag;
  logic [VPN_W-1:0]   fill_pfn;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       table_base_q <= '0;
    else if (cfg_we_i) table_base_q <= cfg_base_i;
  end

  srt_region #(
    .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS),
    .SHADOW_BASE_PAGE(SHADOW_BASE_PAGE), .SHADOW_PAGES(SHADOW_PAGES)
  ) u_region (
    .addr_i(req_addr_i), .in_region_o(in_region), .vpn_o(vpn), .idx_o(idx)
  );

  srt_cam #(
    .ENTRIES(ENTRIES), .TAG_W(VPN_W), .PFN_W(VPN_W)
  ) u_cam (
    .clk_i(clk_i), .rst_ni(rst_ni), .flush_i(flush_i | cfg_we_i),
    .lk_tag_i(vpn), .hit_o(hit), .hit_pfn_o(hit_pfn), .hit_vec_o(hit_vec),
    .fill_i(fill), .fill_tag_i(fill_tag), .fill_pfn_i(fill_pfn)
  );

  srt_walker #(
    .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .IDX_W(IDX_W)
  ) u_walker (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_addr_i(req_addr_i),
    .in_region_i(in_region), .vpn_i(vpn), .idx_i(idx),
    .hit_i(hit), .hit_pfn_i(hit_pfn), .table_base_i(table_base_q),
    .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i),
    .req_ready_o(req_ready_o), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
    .fill_o(fill), .fill_tag_o(fill_tag), .fill_pfn_o(fill_pfn),
    .rsp_valid_o(rsp_valid_o), .rsp_addr_o(rsp_addr_o)
  );
endmodule

// File: rtl/srt_checker.sv
module srt_checker #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned PAGE_BITS = 12,
  parameter int unsigned ENTRIES   = 8,
  localparam int unsigned VPN_W    = ADDR_W - PAGE_BITS
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_valid_i,
  input logic [ADDR_W-1:0]  req_addr_i,
  input logic               req_ready_o,
  input logic               rsp_valid_o,
  input logic [ADDR_W-1:0]  rsp_addr_o,
  input logic               mem_req_o,
  input logic [ADDR_W-1:0]  mem_addr_o,
  input logic               mem_rvalid_i,
  input logic [VPN_W-1:0]   mem_rdata_i,
  input logic               in_region,
  input logic               hit,
  input logic [ENTRIES-1:0] hit_vec
);
  logic                 fire;
  logic [PAGE_BITS-1:0] last_off_q;

  assign fire = req_valid_i && req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   last_off_q <= '0;
    else if (fire) last_off_q <= req_addr_i[PAGE_BITS-1:0];
  end

  a_r1_offset_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> rsp_addr_o[PAGE_BITS-1:0] == last_off_q);

  a_r2_bypass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && !in_region) |=> (rsp_valid_o && !mem_req_o && rsp_addr_o == $past(req_addr_i)));

  a_r3_miss_reads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && in_region && !hit) |=> (mem_req_o && !rsp_valid_o));

  a_r3_fill_reply: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_rvalid_i) |=>
      (!mem_req_o && rsp_valid_o && rsp_addr_o[ADDR_W-1:PAGE_BITS] == $past(mem_rdata_i)));

  a_r4_hit_fast: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && in_region && hit) |=> (rsp_valid_o && !mem_req_o));

  a_r5_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !req_ready_o);

  a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_rvalid_i) |=> (mem_req_o && $stable(mem_addr_o)));

  a_r6_unique_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec));
endmodule

bind shadow_remap_tlb srt_checker #(
  .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .ENTRIES(ENTRIES)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .req_valid_i(req_valid_i), .req_addr_i(req_addr_i), .req_ready_o(req_ready_o),
  .rsp_valid_o(rsp_valid_o), .rsp_addr_o(rsp_addr_o),
  .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
  .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i),
  .in_region(in_region), .hit(hit), .hit_vec(hit_vec)
);

// File: tb/shadow_remap_tlb_tb.sv
module shadow_remap_tlb_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] TBL_A = 32'h0010_0000;
  localparam logic [31:0] TBL_B = 32'h0020_0000;
  localparam logic [31:0] SH0   = 32'h8024_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_base = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_ready;
  logic        rsp_valid;
  logic [31:0] rsp_addr;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [19:0] mem_rdata = '0;

  int total = 0;
  int bad = 0;
  int rd_cnt = 0;
  logic [31:0] last_rd_addr = '0;
  int lat_cnt = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shadow_remap_tlb u_dut (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush),
    .cfg_we_i(cfg_we), .cfg_base_i(cfg_base),
    .req_valid_i(req_valid), .req_addr_i(req_addr), .req_ready_o(req_ready),
    .rsp_valid_o(rsp_valid), .rsp_addr_o(rsp_addr),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata)
  );

  function automatic logic [19:0] pfn_a(int idx);
    case (idx)
      0: return 20'h04012;
      1: return 20'h06155;
      2: return 20'h12011;
      3: return 20'h40138;
      default: return 20'(32'h10000 + idx * 7);
    endcase
  endfunction

  function automatic logic [19:0] pfn_b(int idx);
    return 20'(32'h20000 + idx * 3);
  endfunction

  function automatic logic [19:0] table_word(logic [31:0] a);
    if (a >= TBL_A && a < TBL_A + 32'h1000) return pfn_a(int'((a - TBL_A) >> 2));
    if (a >= TBL_B && a < TBL_B + 32'h1000) return pfn_b(int'((a - TBL_B) >> 2));
    return 20'hFFFFF;
  endfunction

  // table memory: answers three cycles after a request appears
  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (mem_req && !mem_rvalid) begin
      if (lat_cnt == 2) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= table_word(mem_addr);
        lat_cnt    <= 0;
      end else lat_cnt <= lat_cnt + 1;
    end else lat_cnt <= 0;
    if (mem_req && mem_rvalid) begin
      rd_cnt       <= rd_cnt + 1;
      last_rd_addr <= mem_addr;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic [31:0] a, output logic [31:0] r,
                        output int reads, output int lat, output bit stall_bad);
    int n0;
    n0 = rd_cnt;
    stall_bad = 0;
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!rsp_valid && lat < 50) begin
      if (req_ready) stall_bad = 1;
      @(negedge clk);
      lat++;
    end
    r = rsp_addr;
    @(negedge clk);
    reads = rd_cnt - n0;
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
  endtask

  task automatic set_base(logic [31:0] b);
    @(negedge clk); cfg_we = 1'b1; cfg_base = b;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic t_reset();
    chk("R5 reset ready", 32'(req_ready), 32'd1);
    chk("R5 reset rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R5 reset mem_req", 32'(mem_req), 32'd0);
  endtask

  task automatic t_bypass();
    logic [31:0] r; int n, l; bit s;
    access(32'h0000_1234, r, n, l, s);
    chk("R2 low addr passthrough", r, 32'h0000_1234);
    chk("R2 no read", 32'(n), 0);
    chk("R2 one cycle", 32'(l), 1);
    access(32'h8023_FFFC, r, n, l, s);
    chk("R2 just below region", r, 32'h8023_FFFC);
    chk("R2 below region no read", 32'(n), 0);
    access(32'h8064_0010, r, n, l, s);
    chk("R2 just past region", r, 32'h8064_0010);
    chk("R2 past region no read", 32'(n), 0);
  endtask

  task automatic t_miss_hit();
    logic [31:0] r; int n, l; bit s;
    access(SH0 + 32'hABC, r, n, l, s);
    chk("R3 miss translate", r, {pfn_a(0), 12'hABC});
    chk("R1 offset kept on miss", {20'h0, r[11:0]}, 32'hABC);
    chk("R3 one read", 32'(n), 1);
    chk("R3 read address", last_rd_addr, TBL_A);
    chk("R5 stalled while fetching", 32'(s), 0);
    access(SH0 + 32'h004, r, n, l, s);
    chk("R4 hit translate", r, {pfn_a(0), 12'h004});
    chk("R4 hit no read", 32'(n), 0);
    chk("R4 hit one cycle", 32'(l), 1);
  endtask

  task automatic t_scatter();
    logic [31:0] r; int n, l; bit s;
    for (int i = 1; i < 4; i++) begin
      access(SH0 + 32'(i * 4096) + 32'h7F0, r, n, l, s);
      chk("R9 scattered frame", r, {pfn_a(i), 12'h7F0});
      chk("R3 entry address", last_rd_addr, TBL_A + 32'(4 * i));
    end
    access(SH0 + 32'(1023 * 4096) + 32'h008, r, n, l, s);
    chk("R3 last shadow page", r, {pfn_a(1023), 12'h008});
    chk("R3 last entry address", last_rd_addr, TBL_A + 32'(4 * 1023));
  endtask

  task automatic t_replace();
    logic [31:0] r; int n, l; bit s;
    do_flush();
    for (int i = 0; i < 9; i++) access(SH0 + 32'(i * 4096), r, n, l, s);
    access(SH0 + 32'h1000 + 32'h010, r, n, l, s);
    chk("R6 second fill still held", 32'(n), 0);
    chk("R6 second fill value", r, {pfn_a(1), 12'h010});
    access(SH0 + 32'h020, r, n, l, s);
    chk("R6 oldest evicted", 32'(n), 1);
    chk("R6 refetched value", r, {pfn_a(0), 12'h020});
  endtask

  task automatic t_flush();
    logic [31:0] r; int n, l; bit s;
    access(SH0 + 32'h3000, r, n, l, s);
    chk("R7 held before flush", 32'(n), 0);
    do_flush();
    access(SH0 + 32'h3000, r, n, l, s);
    chk("R7 miss after flush", 32'(n), 1);
    chk("R7 value after flush", r, {pfn_a(3), 12'h000});
  endtask

  task automatic t_cfg();
    logic [31:0] r; int n, l; bit s;
    set_base(TBL_B);
    access(SH0 + 32'h3000 + 32'h044, r, n, l, s);
    chk("R8 base write invalidates", 32'(n), 1);
    chk("R8 new table address", last_rd_addr, TBL_B + 32'd12);
    chk("R8 new table frame", r, {pfn_b(3), 12'h044});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    set_base(TBL_A);
    t_bypass();
    t_miss_hit();
    t_scatter();
    t_replace();
    t_flush();
    t_cfg();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule